// File: doc/BRIEF.md
# ADC Conversion Timing Controller

This block generates every timing control needed for one run of analog-to-digital conversions, working from the system clock alone. A programmable divider turns the system clock into ADC clock ticks. When software raises the start bit, the controller waits a fixed power-up interval. It then produces a number of conversion results. Each result comes from two readings of the same channel. Each reading has an acquisition phase, a conversion phase and a short processing gap counted in system clocks.

The acquisition phase can be stretched under software control. If a quick-trip comparator is sampling the same channel when an acquisition is due, the acquisition is held back by two quick-trip conversion periods. The two captured readings are averaged, and the result is presented with a one-cycle valid strobe. After the last result of the run, the controller requests that the start bit be cleared and returns to idle. A new run begins only when the start bit rises again.

Top module: `adc_conv_timer`

## Requirements
- R1: One ADC tick lasts 8·(n+1) system clocks, where n is the 3-bit `div_sel` value. All phase lengths below are counted in these ticks.
- R2: Every reading holds `acq_o` for its acquisition length and then, on the next cycle, holds `conv_o` for exactly 13 ticks. The two outputs are never high together.
- R3: After each conversion phase there are exactly 4 system clocks with neither phase output high before the next phase begins, so each result costs 8 such clocks.
- R4: `res_data` equals (first reading + second reading) >> 1, truncated. `raw_data` is sampled in the last cycle of each conversion phase. `res_valid` is high for one cycle per result.
- R5: A rising edge of `conv_start` in idle starts a 20-tick power-up before the first acquisition. Later results in the same run begin with no power-up.
- R6: The acquisition phase lasts 2 + 2·e ticks when `acq_ext_en` is 1, where e is the 4-bit `acq_ext` value. When `acq_ext_en` is 0 it lasts 2 ticks whatever `acq_ext` holds.
- R7: If `qt_collide` is high when an acquisition is due, that acquisition starts 2·QT_CYC system clocks later (QT_CYC defaults to 16).
- R8: In the cycle of the run's last result (CONVS results, default 2), `start_clear` pulses for one cycle and the block goes idle. A `conv_start` that stays high after this pulse starts no new run.
- R9: While reset is applied, and until the first run, `acq_o`, `conv_o`, `res_valid` and `start_clear` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 3 | ADC clock divider select |
| acq_ext_en | input | 1 | Acquisition extension enable |
| acq_ext | input | 4 | Acquisition extension amount |
| conv_start | input | 1 | Start bit; a rising edge begins a run |
| qt_collide | input | 1 | Quick-trip comparator is on the same channel |
| raw_data | input | 12 | Raw reading from the converter |
| acq_o | output | 1 | Acquisition phase active |
| conv_o | output | 1 | Conversion phase active |
| res_valid | output | 1 | One-cycle strobe for an averaged result |
| res_data | output | 12 | Averaged result |
| start_clear | output | 1 | One-cycle request to clear the start bit |

## Verification
Each phase counter directly sets the length of its phase output. A wrong tick or cycle count therefore shows up as a wrong `acq_o` or `conv_o` pulse width at the first reading. It also moves the `res_valid` strobe off its computed cycle within the same result. A mistaken reading index or capture point shows up as a wrong average on the first result of a run. A wrong run or power-up count appears at the second result or at the `start_clear` pulse, and a held start bit that restarts the block produces phase activity within a few hundred cycles.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_QTWAIT,
    ST_ACQ,
    ST_CONV,
    ST_PROC,
    ST_DONE
  } seq_state_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int SEL_W    = 3,
  parameter int BASE_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);

  localparam int MAX_RATIO = BASE_DIV * (1 << SEL_W);
  localparam int CNT_W     = $clog2(MAX_RATIO);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = CNT_W'((int'(div_sel) + 1) * BASE_DIV - 1);
    tick  = (cnt_q == limit);
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_conv_pkg::*;
#(
  parameter int EXT_W       = 4,
  parameter int PWRUP_TICKS = 20,
  parameter int ACQ_TICKS   = 2,
  parameter int CONV_TICKS  = 13,
  parameter int PROC_CYC    = 4,
  parameter int QT_CYC      = 16,
  parameter int CONVS       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             qt_collide,
  input  logic             ext_en,
  input  logic [EXT_W-1:0] ext_val,
  output logic             div_clr,
  output logic             acq_o,
  output logic             conv_o,
  output logic             cap0,
  output logic             cap1,
  output logic             avg_go,
  output logic             done_o
);

  localparam int ACQ_MAX  = ACQ_TICKS + 2 * ((1 << EXT_W) - 1);
  localparam int MAX_A    = (PWRUP_TICKS > ACQ_MAX) ? PWRUP_TICKS : ACQ_MAX;
  localparam int MAX_T    = (MAX_A > CONV_TICKS) ? MAX_A : CONV_TICKS;
  localparam int TCNT_W   = $clog2(MAX_T);
  localparam int QT_TOT   = 2 * QT_CYC;
  localparam int MAX_S    = (QT_TOT > PROC_CYC) ? QT_TOT : PROC_CYC;
  localparam int SCNT_W   = $clog2(MAX_S);
  localparam int CCNT_W   = (CONVS > 1) ? $clog2(CONVS) : 1;

  seq_state_t        st_q, st_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d, acq_last;
  logic [SCNT_W-1:0] scnt_q, scnt_d;
  logic [CCNT_W-1:0] ccnt_q, ccnt_d;
  logic              rd_q, rd_d;
  logic              start_q;
  logic              go_acq, cap;

  always_comb begin
    acq_last = TCNT_W'(ACQ_TICKS - 1 + (ext_en ? 2 * int'(ext_val) : 0));
    st_d   = st_q;
    tcnt_d = tcnt_q;
    scnt_d = scnt_q;
    ccnt_d = ccnt_q;
    rd_d   = rd_q;
    go_acq = 1'b0;
    cap    = 1'b0;
    avg_go = 1'b0;
    case (st_q)
      ST_IDLE: if (start && !start_q) begin
        st_d   = ST_PWRUP;
        tcnt_d = '0;
        ccnt_d = '0;
        rd_d   = 1'b0;
      end
      ST_PWRUP: if (tick) begin
        if (tcnt_q == TCNT_W'(PWRUP_TICKS - 1)) go_acq = 1'b1;
        else tcnt_d = tcnt_q + 1'b1;
      end
      ST_QTWAIT: begin
        if (scnt_q == SCNT_W'(QT_TOT - 1)) begin
          st_d   = ST_ACQ;
          tcnt_d = '0;
        end else scnt_d = scnt_q + 1'b1;
      end
      ST_ACQ: if (tick) begin
        if (tcnt_q == acq_last) begin
          st_d   = ST_CONV;
          tcnt_d = '0;
        end else tcnt_d = tcnt_q + 1'b1;
      end
      ST_CONV: if (tick) begin
        if (tcnt_q == TCNT_W'(CONV_TICKS - 1)) begin
          st_d   = ST_PROC;
          scnt_d = '0;
          cap    = 1'b1;
        end else tcnt_d = tcnt_q + 1'b1;
      end
      ST_PROC: begin
        if (scnt_q == SCNT_W'(PROC_CYC - 1)) begin
          if (!rd_q) begin
            rd_d   = 1'b1;
            go_acq = 1'b1;
          end else begin
            rd_d   = 1'b0;
            avg_go = 1'b1;
            if (ccnt_q == CCNT_W'(CONVS - 1)) st_d = ST_DONE;
            else begin
              ccnt_d = ccnt_q + 1'b1;
              go_acq = 1'b1;
            end
          end
        end else scnt_d = scnt_q + 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (go_acq) begin
      st_d   = qt_collide ? ST_QTWAIT : ST_ACQ;
      tcnt_d = '0;
      scnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tcnt_q  <= '0;
      scnt_q  <= '0;
      ccnt_q  <= '0;
      rd_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      tcnt_q  <= tcnt_d;
      scnt_q  <= scnt_d;
      ccnt_q  <= ccnt_d;
      rd_q    <= rd_d;
      start_q <= start;
    end
  end

  assign div_clr = (st_d != st_q) || (st_q == ST_IDLE);
  assign acq_o   = (st_q == ST_ACQ);
  assign conv_o  = (st_q == ST_CONV);
  assign done_o  = (st_q == ST_DONE);
  assign cap0    = cap && !rd_q;
  assign cap1    = cap && rd_q;

endmodule

// File: rtl/adc_pair_avg.sv
module adc_pair_avg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap0,
  input  logic          cap1,
  input  logic          go,
  input  logic [DW-1:0] raw,
  output logic          valid,
  output logic [DW-1:0] avg
);

  logic [DW-1:0] r0_q, r1_q;
  logic [DW:0]   sum;

  assign sum = {1'b0, r0_q} + {1'b0, r1_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q  <= '0;
      r1_q  <= '0;
      avg   <= '0;
      valid <= 1'b0;
    end else begin
      if (cap0) r0_q <= raw;
      if (cap1) r1_q <= raw;
      if (go)   avg  <= sum[DW:1];
      valid <= go;
    end
  end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int DW     = 12,
  parameter int SEL_W  = 3,
  parameter int EXT_W  = 4,
  parameter int QT_CYC = 16,
  parameter int CONVS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             acq_ext_en,
  input  logic [EXT_W-1:0] acq_ext,
  input  logic             conv_start,
  input  logic             qt_collide,
  input  logic [DW-1:0]    raw_data,
  output logic             acq_o,
  output logic             conv_o,
  output logic             res_valid,
  output logic [DW-1:0]    res_data,
  output logic             start_clear
);

  logic rst_meta, rst_sync;
  logic tick, div_clr, cap0, cap1, avg_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  adc_clk_div #(.SEL_W(SEL_W), .BASE_DIV(8)) div_i (
    .clk(clk), .rst_n(rst_sync), .clr(div_clr), .div_sel(div_sel), .tick(tick)
  );

  adc_seq_ctrl #(.EXT_W(EXT_W), .QT_CYC(QT_CYC), .CONVS(CONVS)) seq_i (
    .clk(clk), .rst_n(rst_sync), .tick(tick), .start(conv_start),
    .qt_collide(qt_collide), .ext_en(acq_ext_en), .ext_val(acq_ext),
    .div_clr(div_clr), .acq_o(acq_o), .conv_o(conv_o), .cap0(cap0),
    .cap1(cap1), .avg_go(avg_go), .done_o(start_clear)
  );

  adc_pair_avg #(.DW(DW)) avg_i (
    .clk(clk), .rst_n(rst_sync), .cap0(cap0), .cap1(cap1), .go(avg_go),
    .raw(raw_data), .valid(res_valid), .avg(res_data)
  );

endmodule

// File: rtl/adc_conv_timer_chk.sv
module adc_conv_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic acq_o,
  input logic conv_o,
  input logic res_valid,
  input logic start_clear
);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_o && conv_o)); // R2

  AST_ACQ_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq_o) |-> conv_o); // R2

  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R4

  AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_clear |=> !start_clear); // R8

  AST_CLR_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    start_clear |-> res_valid); // R8

  AST_QUIET_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_clear |=> (!acq_o && !conv_o)); // R8

endmodule

bind adc_conv_timer adc_conv_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acq_o(acq_o), .conv_o(conv_o),
  .res_valid(res_valid), .start_clear(start_clear)
);

// File: tb/adc_conv_timer_tb_top.sv
module adc_conv_timer_tb_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  div_sel;
  logic        acq_ext_en;
  logic [3:0]  acq_ext;
  logic        conv_start;
  logic        qt_collide;
  logic [11:0] raw_data;
  logic        acq_o, conv_o, res_valid, start_clear;
  logic [11:0] res_data;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  int acq_run = 0;
  int conv_run = 0;
  bit done_flag = 0;

  int exp_data[$];
  int exp_cyc[$];
  int exp_acq[$];
  int exp_conv[$];

  adc_conv_timer dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .acq_ext_en(acq_ext_en),
    .acq_ext(acq_ext), .conv_start(conv_start), .qt_collide(qt_collide),
    .raw_data(raw_data), .acq_o(acq_o), .conv_o(conv_o),
    .res_valid(res_valid), .res_data(res_data), .start_clear(start_clear)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        if (exp_data.size() == 0) chk("R4 unexpected result", 1, 0);
        else begin
          chk("R4 average", int'(res_data), exp_data.pop_front());
          chk("R3 R5 R7 result cycle", cyc, exp_cyc.pop_front());
        end
      end
      if (acq_o) acq_run++;
      else if (acq_run != 0) begin
        if (exp_acq.size() == 0) chk("R6 unexpected acquisition", 1, 0);
        else chk("R6 acquisition width", acq_run, exp_acq.pop_front());
        acq_run = 0;
      end
      if (conv_o) conv_run++;
      else if (conv_run != 0) begin
        if (exp_conv.size() == 0) chk("R2 unexpected conversion", 1, 0);
        else chk("R2 R1 conversion width", conv_run, exp_conv.pop_front());
        conv_run = 0;
      end
    end
  end

  task automatic wait_conv_end();
    do @(negedge clk); while (!conv_o);
    do @(negedge clk); while (conv_o);
  endtask

  task automatic run(input int sel, input int ext, input int en, input int col,
                     input int d0, input int d1, input int d2, input int d3);
    int r, a, q, p, c0, quiet;
    r = 8 * (sel + 1);
    a = 2 + (en != 0 ? 2 * ext : 0);
    q = (col != 0) ? 32 : 0;
    p = 2 * (q + a * r + 13 * r + 4);
    @(negedge clk);
    div_sel    = 3'(sel);
    acq_ext    = 4'(ext);
    acq_ext_en = (en != 0);
    qt_collide = (col != 0);
    raw_data   = 12'(d0);
    c0 = cyc;
    for (int k = 0; k < 2; k++) exp_cyc.push_back(c0 + 1 + 20 * r + (k + 1) * p);
    exp_data.push_back((d0 + d1) >> 1);
    exp_data.push_back((d2 + d3) >> 1);
    for (int i = 0; i < 4; i++) begin
      exp_acq.push_back(a * r);
      exp_conv.push_back(13 * r);
    end
    conv_start = 1'b1;
    wait_conv_end(); raw_data = 12'(d1);
    wait_conv_end(); raw_data = 12'(d2);
    wait_conv_end(); raw_data = 12'(d3);
    while (!start_clear) @(negedge clk);
    chk("R8 start clear cycle", cyc, c0 + 1 + 20 * r + 2 * p);
    quiet = 0;
    repeat (300) begin
      @(negedge clk);
      if (acq_o || conv_o || start_clear) quiet++;
    end
    chk("R8 held start ignored", quiet, 0);
    conv_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    div_sel = '0; acq_ext = '0; acq_ext_en = 1'b0;
    conv_start = 1'b0; qt_collide = 1'b0; raw_data = '0;
    repeat (4) @(negedge clk);
    chk("R9 reset acq_o", int'(acq_o), 0);
    chk("R9 reset conv_o", int'(conv_o), 0);
    chk("R9 reset res_valid", int'(res_valid), 0);
    chk("R9 reset start_clear", int'(start_clear), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 idle after reset", int'(acq_o | conv_o | start_clear), 0);
    run(0, 0, 0, 0, 100, 201, 4095, 4095);   // R1 fastest, R4 truncation
    run(2, 3, 1, 0, 0, 1, 2048, 2047);       // R6 extension enabled
    run(1, 7, 0, 1, 1000, 3000, 7, 9);       // R6 ignored, R7 collision
    run(0, 0, 1, 0, 4095, 0, 1, 1);          // R6 zero extension
    run(7, 15, 1, 1, 555, 556, 3333, 12);    // R1 slowest, R6 max
    repeat (10) @(negedge clk);
    chk("R4 all results seen", exp_data.size(), 0);
    chk("R2 all phases seen", exp_acq.size() + exp_conv.size(), 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule